// File: doc/BRIEF.md
# Full-Map Directory Controller

This block is the home-node side of a write-invalidate coherence scheme for a small multiprocessor. For every line it owns, it keeps a directory entry made of a dirty flag and one presence bit per processor cache, next to the line's data in a small internal memory. Caches send it read misses, write misses, upgrade requests (a write to a line the cache already holds clean) and evictions. The controller replies with data or with a data-less grant. It sends invalidations only to the caches whose presence bits are set, and it retrieves a dirty line from its owner before it serves anyone else.

One transaction is in flight at a time, and that transaction locks its line. A request for the locked line is refused at once with a nack. A request for any other line is held off with `req_ready` low until the engine is idle again. Cache responses (invalidation acknowledgements and fetched line data) arrive on a separate port. When the owner of a dirty line is the home node's own cache, the controller raises a local strobe and does not put a fetch message on the network.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every directory entry is uncached (dirty flag 0, no presence bit set), and line l of the memory holds the low DW bits of (l * 0x01010101) XOR 0x5A5AC3C3. The outputs `msg_valid`, `nack_valid` and `loc_fetch` are low and `req_ready` is high.
- R2: A read (`req_kind` 0) from cache i to a line that is not dirty produces a reply of kind DATA (`msg_kind` 0) to i. The reply appears in the cycle after acceptance and carries the memory word. Cache i becomes a sharer.
- R3: A read from cache i to a line dirty in cache k (k not the home) sends a FETCH message (`msg_kind` 3) to k. When k returns the line (`rsp_kind` 1), memory takes that data and a DATA reply to i carries it. Afterwards the line is clean with both k and i as sharers.
- R4: When the owner of a dirty line is the home cache (`HOME_ID`), `loc_fetch` pulses for one cycle and no FETCH message is sent. The line is then taken from the response port as in R3.
- R5: A write miss (`req_kind` 1) to an uncached line returns DATA at once, and the requester becomes the sole dirty owner.
- R6: A write miss from i to a clean line sends one invalidation (`msg_kind` 2) per cycle to each sharer other than i, in ascending cache index. It then returns DATA and leaves i as the sole dirty owner.
- R7: A write miss from i to a line dirty in k fetches the line from k, updates memory, replies DATA with that data, and leaves i as the sole dirty owner.
- R8: An upgrade (`req_kind` 2) from a cache holding the line clean invalidates the other sharers and answers with GRANT (`msg_kind` 1), which carries no data. An upgrade from a cache that is not a sharer, or to a dirty line, is served as a write miss.
- R9: No DATA or GRANT reply leaves before an acknowledgement (`rsp_kind` 0) has arrived from every cache invalidated in that transaction.
- R10: An eviction (`req_kind` 3) produces no message. From the owner of a dirty line, it writes `req_data` to memory and makes the entry uncached. On a clean line, it removes only the evicting cache's presence bit. From a non-owner of a dirty line, it has no effect.
- R11: While a transaction is in flight, a request for its line raises `nack_valid` in the same cycle, with `nack_dst` equal to the requester and `req_ready` high, and the request is dropped. A request for another line sees `req_ready` low and no nack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Cache request present |
| req_ready | output | 1 | Request taken (served, or nacked) this cycle |
| req_kind | input | 2 | 0 read, 1 write miss, 2 upgrade, 3 eviction |
| req_src | input | $clog2(NPROC) | Requesting cache index |
| req_line | input | $clog2(NLINES) | Line index |
| req_data | input | DW | Write-back data of an eviction |
| rsp_valid | input | 1 | Cache response present |
| rsp_kind | input | 1 | 0 invalidation acknowledgement, 1 fetched line data |
| rsp_src | input | $clog2(NPROC) | Responding cache index |
| rsp_data | input | DW | Fetched line data |
| msg_valid | output | 1 | Outgoing message present |
| msg_kind | output | 2 | 0 DATA, 1 GRANT, 2 invalidate, 3 fetch |
| msg_dst | output | $clog2(NPROC) | Destination cache |
| msg_line | output | $clog2(NLINES) | Line of the message |
| msg_data | output | DW | Line data of a DATA reply, else zero |
| loc_fetch | output | 1 | Fetch strobe to the home node's own cache |
| nack_valid | output | 1 | Request for the locked line refused |
| nack_dst | output | $clog2(NPROC) | Cache that receives the nack |

## Verification
The refusal of a request for the locked line can fall in the same cycle as the engine's own work on that line: an invalidation or fetch going out, an acknowledgement being absorbed, or the final reply. The bench provokes this by presenting a second request for the same line, from another cache, in the first cycle after a transaction is accepted. In the next cycle it presents a request for a different line. The nack must name the second cache while the expected message still leaves unchanged, and the stalled request must see `req_ready` low. A bench model of the directory then shows, through the messages of later transactions, that neither refused request altered any entry.

// File: rtl/dirctl_pkg.sv
// Shared encodings of the directory controller.
// Assumes: request, message and response codes match the port descriptions.
package dirctl_pkg;

    typedef enum logic [1:0] {
        RQ_READ    = 2'd0,
        RQ_WRITE   = 2'd1,
        RQ_UPGRADE = 2'd2,
        RQ_EVICT   = 2'd3
    } rq_kind_e;

    typedef enum logic [1:0] {
        MS_DATA  = 2'd0,
        MS_GRANT = 2'd1,
        MS_INV   = 2'd2,
        MS_FETCH = 2'd3
    } ms_kind_e;

    localparam logic RS_ACK    = 1'b0;
    localparam logic RS_WBDATA = 1'b1;

    typedef enum logic [2:0] {
        EN_IDLE,
        EN_INV,
        EN_ACKWAIT,
        EN_FETCH,
        EN_FETCHWAIT,
        EN_REPLY
    } en_state_e;

endpackage

// File: rtl/dir_pick.sv
// Lowest-index selector over a bit mask.
// Assumes: the caller checks separately that the mask is non-zero; an empty mask gives index 0.
module dir_pick #(
    parameter int N = 4,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] mask,
    output logic [W-1:0] idx
);

    // scan from the top so that the lowest set bit is the one kept
    always_comb begin
        idx = '0;
        for (int b = N - 1; b >= 0; b--) begin
            if (mask[b]) idx = W'(b);
        end
    end

endmodule

// File: rtl/dir_store.sv
// Directory entries and line data of the home node.
// Each entry holds a dirty flag and a presence vector. Two combinational read
// ports are provided: one for the incoming request line, one for the engine's line.
// Assumes: at most one directory write and one memory write per cycle.
module dir_store #(
    parameter int NPROC  = 4,
    parameter int NLINES = 8,
    parameter int DW     = 32,
    localparam int LINE_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] lk_line,
    output logic              lk_dirty,
    output logic [NPROC-1:0]  lk_pres,
    input  logic [LINE_W-1:0] rd_line,
    output logic [DW-1:0]     rd_data,
    input  logic              dwe,
    input  logic [LINE_W-1:0] dline,
    input  logic              ddirty,
    input  logic [NPROC-1:0]  dpres,
    input  logic              mwe,
    input  logic [LINE_W-1:0] mline,
    input  logic [DW-1:0]     mdata
);

    logic             dir_dirty [NLINES];
    logic [NPROC-1:0] dir_pres  [NLINES];
    logic [DW-1:0]    mem       [NLINES];

    function automatic logic [DW-1:0] init_word(input int l);
        logic [31:0] w;
        w = (32'(l) * 32'h0101_0101) ^ 32'h5A5A_C3C3;
        return DW'(w);
    endfunction

    // combinational lookups for the request path and the reply path
    assign lk_dirty = dir_dirty[lk_line];
    assign lk_pres  = dir_pres[lk_line];
    assign rd_data  = mem[rd_line];

    // reset to uncached entries and a known data pattern, then apply writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < NLINES; l++) begin
                dir_dirty[l] <= 1'b0;
                dir_pres[l]  <= '0;
                mem[l]       <= init_word(l);
            end
        end else begin
            if (dwe) begin
                dir_dirty[dline] <= ddirty;
                dir_pres[dline]  <= dpres;
            end
            if (mwe) mem[mline] <= mdata;
        end
    end

    // a dirty entry names exactly one owner (R5, R7)
    assert_sole_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dwe && ddirty) |-> ($countones(dpres) == 1));

endmodule

// File: rtl/dir_engine.sv
// Transaction engine of the home directory.
// It accepts one request at a time, locks its line, and issues invalidations
// or a fetch. It gathers acknowledgements or fetched data, sends the reply and
// writes back the new entry. It nacks requests for the locked line.
// Assumes: caches answer every invalidation with one acknowledgement and every
// fetch with one data response, and the owner drops its copy on a fetch for a write.
module dir_engine
    import dirctl_pkg::*;
#(
    parameter int NPROC   = 4,
    parameter int NLINES  = 8,
    parameter int DW      = 32,
    parameter int HOME_ID = 0,
    localparam int PID_W  = $clog2(NPROC),
    localparam int LINE_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [PID_W-1:0]  req_src,
    input  logic [LINE_W-1:0] req_line,
    input  logic [DW-1:0]     req_data,
    input  logic              rsp_valid,
    input  logic              rsp_kind,
    input  logic [PID_W-1:0]  rsp_src,
    input  logic [DW-1:0]     rsp_data,
    input  logic              lk_dirty,
    input  logic [NPROC-1:0]  lk_pres,
    output logic [LINE_W-1:0] rd_line,
    input  logic [DW-1:0]     rd_data,
    output logic              dwe,
    output logic [LINE_W-1:0] dline,
    output logic              ddirty,
    output logic [NPROC-1:0]  dpres,
    output logic              mwe,
    output logic [LINE_W-1:0] mline,
    output logic [DW-1:0]     mdata,
    output logic              msg_valid,
    output logic [1:0]        msg_kind,
    output logic [PID_W-1:0]  msg_dst,
    output logic [LINE_W-1:0] msg_line,
    output logic [DW-1:0]     msg_data,
    output logic              loc_fetch,
    output logic              nack_valid,
    output logic [PID_W-1:0]  nack_dst
);

    localparam logic [PID_W-1:0] HOME = PID_W'(HOME_ID);

    en_state_e         state_q;
    logic [LINE_W-1:0] line_q;
    logic [PID_W-1:0]  src_q;
    logic [PID_W-1:0]  owner_q;
    logic [NPROC-1:0]  pend_q;
    logic [NPROC-1:0]  outst_q;
    logic [NPROC-1:0]  fpres_q;
    logic              fdirty_q;
    logic              grant_q;

    logic              idle, accept, same_line, wants_own, upg_ok, fetch_hit;
    logic [NPROC-1:0]  src_bit, others, inv_bit, ack_mask;
    logic [PID_W-1:0]  inv_idx, own_idx;

    // lowest pending invalidation target, and owner of a dirty line
    dir_pick #(.N(NPROC)) inv_pick_i (.mask(pend_q),  .idx(inv_idx));
    dir_pick #(.N(NPROC)) own_pick_i (.mask(lk_pres), .idx(own_idx));

    // request decode and lock checks
    always_comb begin
        idle      = (state_q == EN_IDLE);
        same_line = (req_line == line_q);
        accept    = req_valid && idle;
        src_bit   = {{(NPROC-1){1'b0}}, 1'b1} << req_src;
        others    = lk_pres & ~src_bit;
        wants_own = (req_kind != RQ_READ);
        upg_ok    = (req_kind == RQ_UPGRADE) && !lk_dirty && lk_pres[req_src];
        inv_bit   = {{(NPROC-1){1'b0}}, 1'b1} << inv_idx;
        ack_mask  = (rsp_valid && rsp_kind == RS_ACK) ?
                    ({{(NPROC-1){1'b0}}, 1'b1} << rsp_src) : '0;
        fetch_hit = rsp_valid && (rsp_kind == RS_WBDATA) && (rsp_src == owner_q);
    end

    assign req_ready  = idle || same_line;
    assign nack_valid = req_valid && !idle && same_line;
    assign nack_dst   = req_src;
    assign rd_line    = line_q;
    assign loc_fetch  = (state_q == EN_FETCH) && (owner_q == HOME);

    // outgoing message selected by the engine state
    always_comb begin
        msg_valid = 1'b0;
        msg_kind  = MS_DATA;
        msg_dst   = src_q;
        msg_line  = line_q;
        msg_data  = '0;
        case (state_q)
            EN_INV: begin
                msg_valid = 1'b1;
                msg_kind  = MS_INV;
                msg_dst   = inv_idx;
            end
            EN_FETCH: begin
                msg_valid = (owner_q != HOME);
                msg_kind  = MS_FETCH;
                msg_dst   = owner_q;
            end
            EN_REPLY: begin
                msg_valid = 1'b1;
                msg_kind  = grant_q ? MS_GRANT : MS_DATA;
                msg_data  = grant_q ? '0 : rd_data;
            end
            default: ;
        endcase
    end

    // directory and memory write requests for evictions, fetches and completions
    always_comb begin
        dwe    = 1'b0;
        dline  = line_q;
        ddirty = 1'b0;
        dpres  = '0;
        mwe    = 1'b0;
        mline  = line_q;
        mdata  = rsp_data;
        if (accept && req_kind == RQ_EVICT) begin
            dline = req_line;
            mline = req_line;
            mdata = req_data;
            if (lk_dirty && lk_pres[req_src]) begin
                dwe = 1'b1;
                mwe = 1'b1;
            end else if (!lk_dirty) begin
                dwe   = 1'b1;
                dpres = others;
            end
        end
        if (state_q == EN_FETCHWAIT && fetch_hit) mwe = 1'b1;
        if (state_q == EN_REPLY) begin
            dwe    = 1'b1;
            ddirty = fdirty_q;
            dpres  = fpres_q;
        end
    end

    // engine sequencing: capture, invalidate, wait, fetch, reply
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= EN_IDLE;
            line_q   <= '0;
            src_q    <= '0;
            owner_q  <= '0;
            pend_q   <= '0;
            outst_q  <= '0;
            fpres_q  <= '0;
            fdirty_q <= 1'b0;
            grant_q  <= 1'b0;
        end else begin
            outst_q <= (outst_q & ~ack_mask) | ((state_q == EN_INV) ? inv_bit : '0);
            case (state_q)
                EN_IDLE: begin
                    if (accept && req_kind != RQ_EVICT) begin
                        line_q  <= req_line;
                        src_q   <= req_src;
                        owner_q <= own_idx;
                        grant_q <= upg_ok;
                        if (lk_dirty) begin
                            fdirty_q <= wants_own;
                            fpres_q  <= wants_own ? src_bit : (lk_pres | src_bit);
                            state_q  <= EN_FETCH;
                        end else if (wants_own) begin
                            fdirty_q <= 1'b1;
                            fpres_q  <= src_bit;
                            pend_q   <= others;
                            state_q  <= (others != '0) ? EN_INV : EN_REPLY;
                        end else begin
                            fdirty_q <= 1'b0;
                            fpres_q  <= lk_pres | src_bit;
                            state_q  <= EN_REPLY;
                        end
                    end
                end
                EN_INV: begin
                    pend_q <= pend_q & ~inv_bit;
                    if ((pend_q & ~inv_bit) == '0) state_q <= EN_ACKWAIT;
                end
                EN_ACKWAIT:   if (outst_q == '0) state_q <= EN_REPLY;
                EN_FETCH:     state_q <= EN_FETCHWAIT;
                EN_FETCHWAIT: if (fetch_hit) state_q <= EN_REPLY;
                EN_REPLY:     state_q <= EN_IDLE;
                default:      state_q <= EN_IDLE;
            endcase
        end
    end

    // the reply waits for every acknowledgement (R9)
    assert_acks_before_reply_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (msg_kind == MS_DATA || msg_kind == MS_GRANT))
            |-> (outst_q == '0 && pend_q == '0));

    // the locked line cannot change mid-transaction (R11)
    assert_lock_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != EN_IDLE && $past(state_q) != EN_IDLE) |-> (line_q == $past(line_q)));

    // no cache is invalidated twice in one transaction (R6)
    assert_inv_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MS_INV) |-> !outst_q[msg_dst]);

    // the local strobe never comes with a network fetch (R4)
    assert_local_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        loc_fetch |-> !(msg_valid && msg_kind == MS_FETCH));

endmodule

// File: rtl/dir_home_ctrl.sv
// Home-node full-map directory controller, top level.
// It joins the entry/data store with the transaction engine.
// Assumes: NPROC >= 2 and NLINES >= 2, both powers of two.
module dir_home_ctrl #(
    parameter int NPROC   = 4,
    parameter int NLINES  = 8,
    parameter int DW      = 32,
    parameter int HOME_ID = 0,
    localparam int PID_W  = $clog2(NPROC),
    localparam int LINE_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [PID_W-1:0]  req_src,
    input  logic [LINE_W-1:0] req_line,
    input  logic [DW-1:0]     req_data,
    input  logic              rsp_valid,
    input  logic              rsp_kind,
    input  logic [PID_W-1:0]  rsp_src,
    input  logic [DW-1:0]     rsp_data,
    output logic              msg_valid,
    output logic [1:0]        msg_kind,
    output logic [PID_W-1:0]  msg_dst,
    output logic [LINE_W-1:0] msg_line,
    output logic [DW-1:0]     msg_data,
    output logic              loc_fetch,
    output logic              nack_valid,
    output logic [PID_W-1:0]  nack_dst
);

    logic              lk_dirty, dwe, ddirty, mwe;
    logic [NPROC-1:0]  lk_pres, dpres;
    logic [LINE_W-1:0] rd_line, dline, mline;
    logic [DW-1:0]     rd_data, mdata;

    dir_store #(.NPROC(NPROC), .NLINES(NLINES), .DW(DW)) store_i (
        .clk(clk), .rst_n(rst_n),
        .lk_line(req_line), .lk_dirty(lk_dirty), .lk_pres(lk_pres),
        .rd_line(rd_line), .rd_data(rd_data),
        .dwe(dwe), .dline(dline), .ddirty(ddirty), .dpres(dpres),
        .mwe(mwe), .mline(mline), .mdata(mdata)
    );

    dir_engine #(.NPROC(NPROC), .NLINES(NLINES), .DW(DW), .HOME_ID(HOME_ID)) engine_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_src(req_src), .req_line(req_line), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_src(rsp_src), .rsp_data(rsp_data),
        .lk_dirty(lk_dirty), .lk_pres(lk_pres), .rd_line(rd_line), .rd_data(rd_data),
        .dwe(dwe), .dline(dline), .ddirty(ddirty), .dpres(dpres),
        .mwe(mwe), .mline(mline), .mdata(mdata),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dst(msg_dst),
        .msg_line(msg_line), .msg_data(msg_data), .loc_fetch(loc_fetch),
        .nack_valid(nack_valid), .nack_dst(nack_dst)
    );

endmodule

// File: tb/dir_home_ctrl_tb.sv
`timescale 1ns/100ps
// Bench for the directory controller: directed corner cases followed by seeded
// random traffic, all checked against a bench-side model of directory and memory.
module dir_home_ctrl_tb_top;

    localparam int NP = 4, NL = 8, DW = 32, HOME = 0;
    localparam int PW = $clog2(NP), LW = $clog2(NL);

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          req_valid = 1'b0, req_ready;
    logic [1:0]    req_kind = '0;
    logic [PW-1:0] req_src = '0;
    logic [LW-1:0] req_line = '0;
    logic [DW-1:0] req_data = '0;
    logic          rsp_valid = 1'b0, rsp_kind = 1'b0;
    logic [PW-1:0] rsp_src = '0;
    logic [DW-1:0] rsp_data = '0;
    logic          msg_valid, loc_fetch, nack_valid;
    logic [1:0]    msg_kind;
    logic [PW-1:0] msg_dst, nack_dst;
    logic [LW-1:0] msg_line;
    logic [DW-1:0] msg_data;

    int nchk = 0, nfail = 0;

    logic          m_dirty [NL];
    logic [NP-1:0] m_pres  [NL];
    logic [DW-1:0] m_mem   [NL];

    int            q_due  [16];
    logic          q_kind [16];
    logic [PW-1:0] q_src  [16];
    logic [DW-1:0] q_data [16];
    int            q_head, q_tail;

    always #2.5 clk = ~clk;

    dir_home_ctrl #(.NPROC(NP), .NLINES(NL), .DW(DW), .HOME_ID(HOME)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_src(req_src), .req_line(req_line), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_src(rsp_src), .rsp_data(rsp_data),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dst(msg_dst),
        .msg_line(msg_line), .msg_data(msg_data), .loc_fetch(loc_fetch),
        .nack_valid(nack_valid), .nack_dst(nack_dst)
    );

    function automatic logic [DW-1:0] init_word(input int l);
        return DW'((32'(l) * 32'h0101_0101) ^ 32'h5A5A_C3C3);
    endfunction

    function automatic int lowest(input logic [NP-1:0] m);
        int r = 0;
        for (int p = NP - 1; p >= 0; p--) if (m[p]) r = p;
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push_rsp(input logic k, input int s, input logic [DW-1:0] d, input int due);
        q_kind[q_tail] = k;
        q_src[q_tail]  = PW'(s);
        q_data[q_tail] = d;
        q_due[q_tail]  = due;
        q_tail++;
    endtask

    // one request, its messages, the bench's cache responses and the model update
    task automatic run_txn(input int kind, input int src, input int line,
                           input logic [DW-1:0] wdata, input bit inject, input int ack_dly);
        logic [NP-1:0] pres, sbit, invm;
        logic          dirty, upg_ok, need_fetch, fetch_seen, done, stall_ok;
        logic [DW-1:0] expdata, fd;
        int            owner, other;
        string         dtag;
        pres  = m_pres[line];
        dirty = m_dirty[line];
        sbit  = NP'(1) << src;
        owner = lowest(pres);
        other = src ^ 1;
        need_fetch = dirty && (kind != 3);
        upg_ok     = (kind == 2) && !dirty && pres[src];
        invm       = (!dirty && (kind == 1 || kind == 2)) ? (pres & ~sbit) : '0;
        stall_ok   = need_fetch || (invm != '0);
        expdata    = m_mem[line];
        dtag = need_fetch ? ((kind == 0) ? "R3" : "R7") : ((kind == 0) ? "R2" : "R5");

        req_valid = 1'b1; req_kind = 2'(kind); req_src = PW'(src);
        req_line = LW'(line); req_data = wdata;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "ready while idle", 64'(req_ready), 64'd1);
        @(posedge clk); #1;
        req_valid = 1'b0;

        if (kind == 3) begin
            // R10: eviction model update; no message may follow
            if (dirty && pres[src]) begin
                m_mem[line] = wdata; m_pres[line] = '0; m_dirty[line] = 1'b0;
            end else if (!dirty) begin
                m_pres[line] = pres & ~sbit;
            end
            repeat (3) begin
                @(negedge clk);
                chk(!msg_valid && !loc_fetch, "R10", "message after eviction", 64'(msg_valid), 64'd0);
            end
            @(posedge clk); #1;
            return;
        end

        q_head = 0; q_tail = 0; done = 1'b0; fetch_seen = 1'b0;
        for (int cyc = 0; cyc < 80 && !done; cyc++) begin
            if (inject && cyc == 0) begin
                req_valid = 1'b1; req_kind = 2'd0; req_src = PW'(other); req_line = LW'(line);
            end
            if (inject && cyc == 1 && stall_ok) begin
                req_valid = 1'b1; req_kind = 2'd0; req_src = PW'(other);
                req_line = LW'((line + 1) % NL);
            end
            @(negedge clk);
            if (inject && cyc == 0) begin
                chk(nack_valid && nack_dst == PW'(other) && req_ready, "R11", "nack on locked line",
                    64'({nack_valid, nack_dst}), 64'({1'b1, PW'(other)}));
            end
            if (inject && cyc == 1 && stall_ok) begin
                chk(!req_ready && !nack_valid, "R11", "stall on other line",
                    64'({req_ready, nack_valid}), 64'd0);
            end
            if (loc_fetch) begin
                chk(need_fetch && owner == HOME && !fetch_seen, "R4", "local fetch strobe",
                    64'(owner), 64'(HOME));
                fetch_seen = 1'b1;
                fd = $urandom; expdata = fd;
                push_rsp(1'b1, owner, fd, cyc + 1);
            end
            if (msg_valid) begin
                if (msg_kind == 2'd2) begin
                    chk(invm != '0 && msg_dst == PW'(lowest(invm)), "R6", "invalidate target",
                        64'(msg_dst), 64'(lowest(invm)));
                    invm[msg_dst] = 1'b0;
                    push_rsp(1'b0, int'(msg_dst), '0, cyc + 1 + ack_dly);
                end else if (msg_kind == 2'd3) begin
                    chk(need_fetch && owner != HOME && msg_dst == PW'(owner) && !fetch_seen,
                        "R3", "fetch target", 64'(msg_dst), 64'(owner));
                    fetch_seen = 1'b1;
                    fd = $urandom; expdata = fd;
                    push_rsp(1'b1, owner, fd, cyc + 1);
                end else begin
                    done = 1'b1;
                    chk(q_head == q_tail && invm == '0 && (fetch_seen || !need_fetch), "R9",
                        "reply before acks", 64'(q_tail - q_head), 64'd0);
                    chk(msg_kind == (upg_ok ? 2'd1 : 2'd0), "R8", "reply kind",
                        64'(msg_kind), 64'(upg_ok));
                    chk(msg_dst == PW'(src) && msg_line == LW'(line), dtag, "reply address",
                        64'({msg_dst, msg_line}), 64'({PW'(src), LW'(line)}));
                    if (!upg_ok)
                        chk(msg_data == expdata, dtag, "reply data", 64'(msg_data), 64'(expdata));
                end
            end
            @(posedge clk); #1;
            req_valid = 1'b0; rsp_valid = 1'b0;
            if (q_head != q_tail && q_due[q_head] <= cyc + 1) begin
                rsp_valid = 1'b1; rsp_kind = q_kind[q_head];
                rsp_src = q_src[q_head]; rsp_data = q_data[q_head];
                q_head++;
            end
        end
        if (!done) chk(1'b0, dtag, "no reply", 64'd0, 64'd1);
        if (rsp_valid) begin
            @(posedge clk); #1;
            rsp_valid = 1'b0;
        end

        if (need_fetch) m_mem[line] = expdata;
        if (kind == 0) begin
            m_pres[line]  = dirty ? ((NP'(1) << owner) | sbit) : (pres | sbit);
            m_dirty[line] = 1'b0;
        end else begin
            m_pres[line]  = sbit;
            m_dirty[line] = 1'b1;
        end
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    // directed corner cases, then seeded random traffic
    initial begin
        void'($urandom(32'd20240611));
        for (int l = 0; l < NL; l++) begin
            m_dirty[l] = 1'b0; m_pres[l] = '0; m_mem[l] = init_word(l);
        end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !msg_valid && !nack_valid && !loc_fetch, "R1", "idle after reset",
            64'({req_ready, msg_valid, nack_valid, loc_fetch}), 64'b1000);
        @(posedge clk); #1;

        run_txn(0, 1, 0, '0, 1'b0, 0);            // R1 R2: read of the reset pattern
        run_txn(0, 2, 0, '0, 1'b0, 0);            // R2: second sharer
        run_txn(1, 3, 0, '0, 1'b1, 3);            // R6 R9 R11: invalidate 1 and 2, late acks, nack
        run_txn(0, 1, 0, '0, 1'b1, 0);            // R3: fetch from remote owner 3
        run_txn(1, 0, 2, '0, 1'b0, 0);            // R5: write miss on uncached line
        run_txn(0, 1, 2, '0, 1'b1, 0);            // R4: owner is the home cache
        run_txn(1, 1, 5, '0, 1'b0, 0);            // R5
        run_txn(1, 2, 5, '0, 1'b1, 1);            // R7: write miss on dirty line
        run_txn(0, 1, 3, '0, 1'b0, 0);
        run_txn(0, 2, 3, '0, 1'b0, 0);
        run_txn(2, 1, 3, '0, 1'b1, 2);            // R8: upgrade by clean holder gives grant
        run_txn(2, 3, 3, '0, 1'b0, 0);            // R8: upgrade by non-holder acts as write miss
        run_txn(3, 0, 3, 32'hDEAD0001, 1'b0, 0);  // R10: eviction by non-owner ignored
        run_txn(0, 0, 3, '0, 1'b0, 0);            // fetch still needed from owner 3
        run_txn(1, 2, 6, '0, 1'b0, 0);
        run_txn(3, 2, 6, 32'hBEEF0002, 1'b0, 0);  // R10: dirty write-back
        run_txn(0, 0, 6, '0, 1'b0, 0);            // R10: data from memory, no fetch
        run_txn(0, 1, 4, '0, 1'b0, 0);
        run_txn(0, 2, 4, '0, 1'b0, 0);
        run_txn(3, 1, 4, '0, 1'b0, 0);            // R10: clean eviction drops only cache 1
        run_txn(1, 3, 4, '0, 1'b0, 0);            // R6: invalidation goes to cache 2 only

        for (int t = 0; t < 300; t++) begin
            run_txn(int'($urandom % 4), int'($urandom % NP), int'($urandom % 4),
                    $urandom, ($urandom % 3) == 0, int'($urandom % 4));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule